// File: doc/BRIEF.md
# Threshold-Gated Byte FIFO for DMA Flow Control

This block buffers bytes between the media side and the host side of a disk-style data path. The media side pushes bytes and the host side pops them. A registered occupancy count is compared against two watermarks. The media side uses the upper watermark to stop read-ahead before the buffer overruns. The host side uses the lower watermark to stop requesting or strobing before the buffer underruns.

Both watermarks are set by 3-bit codes in one control byte, which can be written and read through a small register port. A mode input selects the host transfer style. In legacy DMA mode the lower watermark gates the request line. In Ultra DMA data-in mode it gates strobe generation instead. Bus timing, CRC and media decoding belong to other blocks. This block supplies only the FIFO data and the qualified enables.

Top module: `fifo_flow_ctl`

## Requirements
- R1: After reset the FIFO is empty (level 0, empty high, full low), the control byte reads 0x08, prefetch enable is high, and both host-side enables are low.
- R2: Bytes leave in the order they entered, and `pop_data_o` shows the oldest stored byte whenever the FIFO is not empty.
- R3: The FIFO holds 32 bytes. A push is accepted only while the level is below 32, and a pop only while the level is above 0. Full means level 32 and empty means level 0.
- R4: Control byte layout: bits 5:3 hold the upper code and bits 2:0 hold the lower code. Bits 7:6 read as zero and writes to them have no effect.
- R5: Upper code decode: 000 gives 28 bytes, 001 gives 24, 011 gives 16, and any other code gives 24.
- R6: Lower code decode: 000 gives 4 bytes, 001 gives 8, 011 gives 16, and any other code gives 4.
- R7: `prefetch_en_o` is low exactly when the level is greater than the upper watermark.
- R8: With `udma_mode_i` = 0, `dma_req_en_o` is high exactly when the level is not below the lower watermark, and `strobe_en_o` is low.
- R9: With `udma_mode_i` = 1, `strobe_en_o` is high exactly when the level is not below the lower watermark, and `dma_req_en_o` is low.
- R10: All enables follow the registered level. A push or pop changes them only after the next rising clock edge. A push and a pop in the same cycle on a non-empty, non-full FIFO leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe from media side |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe from host side |
| pop_data_o | output | 8 | Oldest stored byte |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| level_o | output | 6 | Registered occupancy count |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read data |
| udma_mode_i | input | 1 | 1 = Ultra DMA data-in, 0 = legacy DMA |
| prefetch_en_o | output | 1 | Media read-ahead allowed |
| dma_req_en_o | output | 1 | Legacy DMA request allowed |
| strobe_en_o | output | 1 | Ultra DMA strobe allowed |

## Verification
The hardest situation to reach is the upper watermark at code 000. There, prefetch drops only when the level is 29 to 32, which means the bench must keep the FIFO nearly full while also pushing into it and popping from it. The random stimulus runs in phases with different push and pop probabilities. Push-heavy phases hold the level near the top, and drain-heavy phases sweep it down through the lower watermarks. Control writes with random codes, including unlisted codes and set reserved bits, are mixed in. Directed sequences fill to 32, push into a full FIFO, pop an empty one, and probe the enables just before and just after the edge that crosses a watermark.

// File: rtl/fifo_flow_pkg.sv
package fifo_flow_pkg;
  typedef struct packed {
    logic [2:0] hi_code;
    logic [2:0] lo_code;
  } thr_cfg_t;

  localparam logic [2:0] HI_RST = 3'b001;
  localparam logic [2:0] LO_RST = 3'b000;

  function automatic int unsigned hi_bytes(logic [2:0] code);
    case (code)
      3'b000:  return 28;
      3'b011:  return 16;
      default: return 24;
    endcase
  endfunction

  function automatic int unsigned lo_bytes(logic [2:0] code);
    case (code)
      3'b001:  return 8;
      3'b011:  return 16;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/flow_thr_reg.sv
module flow_thr_reg
  import fifo_flow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output thr_cfg_t   cfg_o,
  output logic [7:0] rdata_o
);
  thr_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.hi_code <= HI_RST;
      cfg_q.lo_code <= LO_RST;
    end else if (we_i) begin
      cfg_q.hi_code <= wdata_i[5:3];
      cfg_q.lo_code <= wdata_i[2:0];
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {2'b00, cfg_q.hi_code, cfg_q.lo_code};

  // R4
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == {2'b00, $past(wdata_i[5:0])});
endmodule

// File: rtl/flow_byte_fifo.sv
module flow_byte_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (count_q != FULL_CNT);
  assign pop_ok  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];
  assign count_o    = count_q;
  assign full_o     = (count_q == FULL_CNT);
  assign empty_o    = (count_q == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  // R3
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  // R3
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_q));
  // R10
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_q) - int'($past(count_q))) inside {-1, 0, 1});
endmodule

// File: rtl/flow_thr_cmp.sv
module flow_thr_cmp
  import fifo_flow_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  thr_cfg_t      cfg_i,
  input  logic          udma_mode_i,
  output logic          prefetch_en_o,
  output logic          dma_req_en_o,
  output logic          strobe_en_o
);
  logic above_hi, below_lo;

  always_comb begin
    above_hi = int'(count_i) > int'(hi_bytes(cfg_i.hi_code));
    below_lo = int'(count_i) < int'(lo_bytes(cfg_i.lo_code));
  end

  assign prefetch_en_o = !above_hi;
  assign dma_req_en_o  = !udma_mode_i && !below_lo;
  assign strobe_en_o   =  udma_mode_i && !below_lo;

  // R8
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_req_en_o, strobe_en_o}));
endmodule

// File: rtl/fifo_flow_ctl.sv
module fifo_flow_ctl
  import fifo_flow_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] level_o,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_wdata_i,
  output logic [7:0]    cfg_rdata_o,
  input  logic          udma_mode_i,
  output logic          prefetch_en_o,
  output logic          dma_req_en_o,
  output logic          strobe_en_o
);
  thr_cfg_t      cfg;
  logic [CW-1:0] count;

  flow_thr_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  flow_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .count_o     (count),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  flow_thr_cmp #(.CW(CW)) u_cmp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .count_i       (count),
    .cfg_i         (cfg),
    .udma_mode_i   (udma_mode_i),
    .prefetch_en_o (prefetch_en_o),
    .dma_req_en_o  (dma_req_en_o),
    .strobe_en_o   (strobe_en_o)
  );

  assign level_o = count;

  // R7
  full_no_prefetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !prefetch_en_o);
  // R9
  empty_no_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !(dma_req_en_o || strobe_en_o));
endmodule

// File: tb/sim_fifo_flow_ctl.sv
module sim_fifo_flow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0, cfg_we = 1'b0, udma = 1'b0;
  logic [7:0] push_data = '0, cfg_wdata = '0;
  logic [7:0] pop_data, cfg_rdata;
  logic [5:0] level;
  logic       full, empty, pf_en, dma_en, stb_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] q_m[$];
  logic [5:0] cfg_m = 6'b001_000;
  bit         mode_m = 1'b0;

  always #10 clk = ~clk;

  fifo_flow_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .pop_data_o(pop_data), .full_o(full), .empty_o(empty),
    .level_o(level), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .udma_mode_i(udma), .prefetch_en_o(pf_en),
    .dma_req_en_o(dma_en), .strobe_en_o(stb_en)
  );

  function automatic int hi_of(logic [2:0] c);
    if (c == 3'b000) return 28;
    if (c == 3'b011) return 16;
    return 24;
  endfunction

  function automatic int lo_of(logic [2:0] c);
    if (c == 3'b001) return 8;
    if (c == 3'b011) return 16;
    return 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    int n = q_m.size();
    chk("R3 level", int'(level), n);
    chk("R3 full", int'(full), int'(n == 32));
    chk("R3 empty", int'(empty), int'(n == 0));
    chk("R4 cfg readback", int'(cfg_rdata), int'({2'b00, cfg_m}));
    chk("R7/R5 prefetch", int'(pf_en), int'(!(n > hi_of(cfg_m[5:3]))));
    chk("R8/R6 dma req", int'(dma_en), int'(!mode_m && n >= lo_of(cfg_m[2:0])));
    chk("R9/R6 strobe", int'(stb_en), int'(mode_m && n >= lo_of(cfg_m[2:0])));
    if (n > 0) chk("R2 pop data", int'(pop_data), int'(q_m[0]));
  endtask

  task automatic cycle(bit p, logic [7:0] d, bit q, bit w, logic [7:0] wd, bit m);
    @(negedge clk);
    check_all();
    push = p; push_data = d; pop = q; cfg_we = w; cfg_wdata = wd; udma = m;
    begin
      int n = q_m.size();
      if (q && n > 0) void'(q_m.pop_front());
      if (p && n < 32) q_m.push_back(d);
      if (w) cfg_m = wd[5:0];
      mode_m = m;
    end
  endtask

  task automatic idle();
    cycle(0, 8'h00, 0, 0, 8'h00, mode_m);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 cfg", int'(cfg_rdata), 8'h08);
    chk("R1 prefetch", int'(pf_en), 1);
    chk("R1 host enables", int'({dma_en, stb_en}), 0);

    // R3 pop on empty ignored
    cycle(0, 8'h00, 1, 0, 8'h00, 0);
    idle();

    // R4 reserved bits ignored; unlisted codes -> defaults (R5, R6)
    cycle(0, 8'h00, 0, 1, 8'hFF, 0);
    idle();
    chk("R4 reserved read zero", int'(cfg_rdata), 8'h3F);

    // R10: hi=16, lo=16; fill to 16 then probe around the crossing edge
    cycle(0, 8'h00, 0, 1, 8'b00_011_011, 0);
    for (int i = 0; i < 16; i++) cycle(1, 8'(i + 8'h40), 0, 0, 8'h00, 0);
    idle();
    cycle(1, 8'hA5, 0, 0, 8'h00, 0);
    #5;
    chk("R10 prefetch before edge", int'(pf_en), 1);
    chk("R10 level before edge", int'(level), 16);
    idle();
    chk("R10 prefetch after edge", int'(pf_en), 0);
    // R10 simultaneous push and pop keeps level
    cycle(1, 8'hB6, 1, 0, 8'h00, 1);
    idle();
    chk("R10 push+pop level", int'(level), 17);

    // R3 fill to full with hi=28, then push into full
    cycle(0, 8'h00, 0, 1, 8'b00_000_001, 1);
    for (int i = 0; i < 20; i++) cycle(1, 8'(i + 8'h80), 0, 0, 8'h00, 1);
    idle();
    chk("R3 full at 32", int'(full), 1);
    cycle(1, 8'hEE, 0, 0, 8'h00, 1);
    idle();
    // R2 drain in order, crossing lo=8 in Ultra DMA mode (R9)
    for (int i = 0; i < 34; i++) cycle(0, 8'h00, 1, 0, 8'h00, 1);
    idle();

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      int pp = (ph % 3 == 0) ? 85 : ((ph % 3 == 1) ? 20 : 55);
      for (int i = 0; i < 300; i++) begin
        bit p  = ($urandom % 100) < pp;
        bit q  = ($urandom % 100) < (100 - pp);
        bit w  = ($urandom % 100) < 3;
        bit m  = (($urandom % 100) < 8) ? ~mode_m : mode_m;
        cycle(p, 8'($urandom), q, w, 8'($urandom), m);
      end
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule